// File: doc/BRIEF.md
# Prime-Field Add/Subtract Unit

This block returns either the sum or the difference of two residues modulo a prime `p`, with `p` supplied on an input. The operands are assumed to be residues already, so both lie in `[0, p)`, and the result lands in the same range without any separate reduction step. It is meant to serve as the shared adder inside the processing elements and inverter of an elliptic-curve engine. Because `p` is an input, the same hardware can switch between curves at run time.

Two candidates are built side by side for each operation. The plain path adds or subtracts the operands. The fixing path applies the correction by `p` at the same time. It merges its three inputs with one row of full adders and then a single ripple adder, rather than two ripple adders in series. Both paths take the subtrahend from a multiplexer that picks the true or the inverted operand. The final choice comes from the sign bit of one of the paths.

The arithmetic itself is combinational. A single output register is wrapped around it so that a bench can sample the result at a known cycle: a result appears one clock after its operands are presented.

Top module: `modaddsub`

## Requirements
- R1: With `sub` = 0 and a + b < p, `result` equals a + b.
- R2: With `sub` = 0 and a + b ≥ p, `result` equals a + b − p. This includes a + b = p, which gives 0.
- R3: With `sub` = 1 and a ≥ b, `result` equals a − b. This includes a = b, which gives 0.
- R4: With `sub` = 1 and a < b, `result` equals a − b + p.
- R5: For operands in `[0, p)`, every valid `result` is strictly below `p`.
- R6: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` is high, and it is low otherwise.
- R7: While `in_valid` is low, `result` keeps its last value.
- R8: After reset, `out_valid` is 0 and `result` is 0.
- R9: Every bit up to the top bit of the default 521-bit width is handled, including operands next to a Mersenne-form modulus of that width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| sub | input | 1 | 0 selects add, 1 selects subtract |
| a | input | N | First operand, below p |
| b | input | N | Second operand, below p |
| p | input | N | Prime modulus |
| out_valid | output | 1 | Result register holds a new value |
| result | output | N | Reduced sum or difference |

## Verification
Each operation is driven on both sides of its correction boundary. Additions are chosen to sum below p, exactly to p, and above p. Subtractions cover a larger minuend, equal operands, and a smaller minuend. Comparing these cases shows whether the select logic picks the right path and whether the borrow and carry-in handling is off by one. A modulus of 13 exposes low-bit errors. Random residues are run against 2^255−19, and extreme residues against 2^521−1, so that a fault confined to the high carry chain or the sign bit still shows. Back-to-back and gapped input streams, followed by idle cycles, distinguish correct latency and holding of the output from a register that is stale or leaks values.

// File: rtl/modaddsub_pkg.sv
package modaddsub_pkg;

    localparam int unsigned DEF_WIDTH = 521;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/mas_csa3.sv
// One row of full adders that compresses three vectors into a sum vector
// and a carry vector. The carry vector is returned already moved up one
// place, with the injected carry-in filling bit 0.
module mas_csa3 #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    input  logic         cin,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_sh_o
);

    assign carry_sh_o[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = x[i] ^ y[i] ^ z[i];
        if (i < W - 1) begin : g_cy
            assign carry_sh_o[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
        end
    end

endmodule

// File: rtl/mas_ripple.sv
// Two-operand ripple-carry adder. The sum wraps modulo 2^W.
module mas_ripple #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] cy;

    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = x[i] ^ y[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
        end
    end

endmodule

// File: rtl/mas_core.sv
// Combinational dual-path modular add/subtract.
module mas_core
    import modaddsub_pkg::*;
#(
    parameter int unsigned N = DEF_WIDTH
) (
    input  logic         sub,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N-1:0] p,
    output logic [N-1:0] res_o
);

    // One guard bit above the operand width carries the sign.
    localparam int unsigned W = N + 1;

    op_e          op;
    logic [W-1:0] a_x;
    logic [W-1:0] b_x;
    logic [W-1:0] p_x;
    logic [W-1:0] b_sel;
    logic [W-1:0] p_sel;
    logic [W-1:0] plain_sum;
    logic [W-1:0] cs_sum;
    logic [W-1:0] cs_carry;
    logic [W-1:0] fix_sum;
    logic         take_fix;

    always_comb begin
        op    = op_e'(sub);
        a_x   = {1'b0, a};
        b_x   = {1'b0, b};
        p_x   = {1'b0, p};
        // Subtract: invert b and add one. Add: invert p on the fixing path.
        b_sel = (op == OP_SUB) ? ~b_x : b_x;
        p_sel = (op == OP_SUB) ? p_x  : ~p_x;
    end

    // Plain path: a +/- b. The carry-in completes the two's complement of b.
    mas_ripple #(.W(W)) u_plain (
        .x     (a_x),
        .y     (b_sel),
        .cin   (sub),
        .sum_o (plain_sum)
    );

    // Fixing path: a +/- b -/+ p. Both cases need exactly one +1.
    mas_csa3 #(.W(W)) u_csa (
        .x          (a_x),
        .y          (b_sel),
        .z          (p_sel),
        .cin        (1'b1),
        .sum_o      (cs_sum),
        .carry_sh_o (cs_carry)
    );

    mas_ripple #(.W(W)) u_fix (
        .x     (cs_sum),
        .y     (cs_carry),
        .cin   (1'b0),
        .sum_o (fix_sum)
    );

    always_comb begin
        // Add: take a+b-p unless it went negative.
        // Subtract: take a-b+p when a-b went negative.
        if (op == OP_SUB) begin
            take_fix = plain_sum[N];
        end else begin
            take_fix = ~fix_sum[N];
        end
        res_o = take_fix ? fix_sum[N-1:0] : plain_sum[N-1:0];
    end

endmodule

// File: rtl/modaddsub.sv
module modaddsub
    import modaddsub_pkg::*;
#(
    parameter int unsigned N = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         sub,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N-1:0] p,
    output logic         out_valid,
    output logic [N-1:0] result
);

    typedef struct packed {
        logic         vld;
        logic [N-1:0] res;
    } state_t;

    state_t       st_d;
    state_t       st_q;
    logic [N-1:0] core_res;

    mas_core #(.N(N)) u_core (
        .sub   (sub),
        .a     (a),
        .b     (b),
        .p     (p),
        .res_o (core_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = core_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

endmodule

// File: rtl/modaddsub_chk.sv
module modaddsub_chk #(
    parameter int unsigned N = 521
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         sub,
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic [N-1:0] p,
    input logic         out_valid,
    input logic [N-1:0] result
);

    logic [N:0] a_c;
    logic [N:0] b_c;
    logic [N:0] p_c;
    logic       sub_c;
    logic [N:0] r_x;
    logic [N:0] sum_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_c   <= '0;
            b_c   <= '0;
            p_c   <= '0;
            sub_c <= 1'b0;
        end else if (in_valid) begin
            a_c   <= {1'b0, a};
            b_c   <= {1'b0, b};
            p_c   <= {1'b0, p};
            sub_c <= sub;
        end
    end

    assign r_x   = {1'b0, result};
    assign sum_c = a_c + b_c;

    // R6
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R5
    below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (r_x < p_c));

    // R1 R2
    add_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sub_c) |-> (r_x == ((sum_c >= p_c) ? (sum_c - p_c) : sum_c)));

    // R3 R4
    sub_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sub_c) |-> ((r_x + b_c == a_c) || (r_x + b_c == a_c + p_c)));

endmodule

bind modaddsub modaddsub_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sub       (sub),
    .a         (a),
    .b         (b),
    .p         (p),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_modaddsub.sv
module sim_modaddsub;

    localparam int unsigned N = 521;

    typedef struct {
        logic [N-1:0] exp;
        logic [N-1:0] modp;
        longint       due;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         sub = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [N-1:0] p = '0;
    logic         out_valid;
    logic [N-1:0] result;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    item_t  sb[$];
    logic [N-1:0] last_exp = '0;
    logic   done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    modaddsub #(.N(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sub       (sub),
        .a         (a),
        .b         (b),
        .p         (p),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [N-1:0] ref_val(logic [N-1:0] x, logic [N-1:0] y,
                                             logic [N-1:0] m, logic s);
        logic [N:0] t;
        if (!s) begin
            t = {1'b0, x} + {1'b0, y};
            if (t >= {1'b0, m}) t = t - {1'b0, m};
        end else if (x >= y) begin
            t = {1'b0, x} - {1'b0, y};
        end else begin
            t = ({1'b0, m} - {1'b0, y}) + {1'b0, x};
        end
        return t[N-1:0];
    endfunction

    function automatic logic [N-1:0] rnd_below(logic [N-1:0] m);
        logic [N+31:0] acc;
        logic [N+31:0] rem;
        acc = '0;
        for (int i = 0; i < (N + 31) / 32 + 1; i++) begin
            acc = {acc[N-1:0], $urandom()};
        end
        rem = acc % {32'b0, m};
        return rem[N-1:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] got,
                         input logic [N-1:0] want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, want);
        end
    endtask

    task automatic push_op(input logic [N-1:0] x, input logic [N-1:0] y,
                           input logic [N-1:0] m, input logic s, input string tag_in);
        item_t it;
        @(negedge clk);
        a        = x;
        b        = y;
        p        = m;
        sub      = s;
        in_valid = 1'b1;
        it.exp   = ref_val(x, y, m, s);
        it.modp  = m;
        it.due   = cyc + 1;
        if (tag_in != "") it.tag = tag_in;
        else if (!s) it.tag = ({1'b0, x} + {1'b0, y} < {1'b0, m}) ? "R1" : "R2";
        else it.tag = (x >= y) ? "R3" : "R4";
        last_exp = it.exp;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a = '1;
            b = '1;
            sub = ~sub;
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                item_t it;
                it = sb.pop_front();
                check(out_valid === 1'b1, "R6", {{(N-1){1'b0}}, out_valid}, 1);
                check(result === it.exp, it.tag, result, it.exp);
                check({1'b0, result} < {1'b0, it.modp}, "R5", result, it.modp);
            end else if (out_valid !== 1'b0) begin
                check(1'b0, "R6", {{(N-1){1'b0}}, out_valid}, 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        logic [N-1:0] p13;
        logic [N-1:0] p255;
        logic [N-1:0] p521;
        p13  = N'(13);
        p255 = (N'(1) << 255) - N'(19);
        p521 = '1;

        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid === 1'b0, "R8", {{(N-1){1'b0}}, out_valid}, 0);
        check(result === '0, "R8", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R8", {{(N-1){1'b0}}, out_valid}, 0);

        // Small modulus, boundary cases
        push_op(N'(5),  N'(6),  p13, 1'b0, "R1");
        push_op(N'(7),  N'(6),  p13, 1'b0, "R2");
        push_op(N'(12), N'(12), p13, 1'b0, "R2");
        push_op(N'(0),  N'(0),  p13, 1'b0, "R1");
        push_op(N'(9),  N'(4),  p13, 1'b1, "R3");
        push_op(N'(4),  N'(4),  p13, 1'b1, "R3");
        push_op(N'(3),  N'(10), p13, 1'b1, "R4");
        push_op(N'(0),  N'(12), p13, 1'b1, "R4");
        idle(3);
        // R7: output held while idle
        check(out_valid === 1'b0, "R7", {{(N-1){1'b0}}, out_valid}, 0);
        check(result === last_exp, "R7", result, last_exp);

        // 255-bit prime, back to back random
        for (int i = 0; i < 60; i++) begin
            push_op(rnd_below(p255), rnd_below(p255), p255, 1'($urandom() & 1), "");
        end
        push_op(p255 - N'(1), N'(1), p255, 1'b0, "R2");
        push_op(N'(1), p255 - N'(1), p255, 1'b1, "R4");

        // Full width with gaps
        push_op(p521 - N'(1), p521 - N'(1), p521, 1'b0, "R9");
        idle(1);
        push_op(N'(0), p521 - N'(1), p521, 1'b1, "R9");
        push_op(p521 - N'(1), N'(0), p521, 1'b1, "R9");
        push_op(N'(1) << (N - 2), N'(1) << (N - 2), p521, 1'b0, "R9");
        for (int i = 0; i < 60; i++) begin
            push_op(rnd_below(p521), rnd_below(p521), p521, 1'($urandom() & 1), "");
            if (i % 7 == 0) idle(2);
        end
        idle(4);
        check(out_valid === 1'b0, "R7", {{(N-1){1'b0}}, out_valid}, 0);
        check(result === last_exp, "R7", result, last_exp);
        check(sb.size() == 0, "R6", N'(sb.size()), '0);
        done = 1'b1;
        report();
    end

endmodule